// File: doc/BRIEF.md
# Pipelined Unified CORDIC Iteration Core

This block is a fixed-point shift-and-add rotation engine. It is fully pipelined. Each of its stages applies one micro-rotation to an (X, Y, Z) triple. A two-bit coordinate selector picks the geometry for each sample: linear, circular or hyperbolic. A mode bit picks how each stage chooses its rotation direction. Rotation mode drives Z toward zero, and vectoring mode drives Y toward zero. One datapath can therefore produce sine and cosine, arctangent and vector magnitude, hyperbolic sine, cosine and arctangent, products and quotients.

A new sample can enter on every clock. The coordinate system and mode of that sample travel with it. Samples of different kinds can therefore sit in adjacent stages. A caller tag rides along so results can be matched to requests. Operands and results are signed two's-complement numbers with 4 integer bits and 28 fraction bits. The caller handles conversion to or from floating point, range reduction and gain correction.

Top module: `cordic_core`

## Requirements
- R1: Every accepted sample leaves the pipeline exactly 23 clock cycles after it is presented, on the 23rd rising edge after capture. It carries the same tag it entered with.
- R2: With selector 2'b00 (linear) in rotation mode (mode bit 0), X is passed through unchanged and Y becomes Y + X·Z, accurate to about 1e-5, for |Z| < 2.
- R3: With selector 2'b00 in vectoring mode (mode bit 1), X is unchanged and Z becomes Z + Y/X, for |Y/X| < 2.
- R4: With selector 2'b01 (circular) in rotation mode, (X, Y) is rotated by angle Z and scaled by the circular gain, the product over s = 0..22 of sqrt(1 + 2^-2s).
- R5: With selector 2'b01 in vectoring mode, Z accumulates atan(Y/X). X becomes the circular gain times sqrt(X² + Y²), and Y goes to about zero.
- R6: With selector 2'b11 (hyperbolic) in rotation mode, the stages use shift amounts 1,2,3,4,4,5,…,13,13,14,…,21. The result is (X cosh Z + Y sinh Z, X sinh Z + Y cosh Z), scaled by the product of sqrt(1 − 2^-2s) over that schedule.
- R7: With selector 2'b11 in vectoring mode, Z accumulates atanh(Y/X), and X becomes the hyperbolic gain times sqrt(X² − Y²).
- R8: Direction rule: in rotation mode a stage adds its angle to the rotation when Z ≥ 0 and subtracts it when Z < 0. In vectoring mode it does the same when Y < 0 and when Y ≥ 0 respectively. Negative and positive arguments therefore give mirrored results.
- R9: A synchronous active-high reset clears every stage's valid flag. After reset, no output is valid until a new sample has traversed all stages, even if samples were in flight.
- R10: The pipeline takes one sample per clock with mixed selectors and modes back to back or with gaps. Each result equals the 23-step iteration of its own operands, within 8 LSB.
- R11: The unused selector code 2'b10 behaves exactly as linear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Sample present on the inputs this cycle |
| in_coord | input | 2 | Geometry: 00 linear, 01 circular, 11 hyperbolic, 10 as linear |
| in_vect | input | 1 | 0 rotation mode, 1 vectoring mode |
| in_tag | input | 4 | Caller tag carried with the sample |
| in_x | input | 32 | X operand, signed Q4.28 |
| in_y | input | 32 | Y operand, signed Q4.28 |
| in_z | input | 32 | Z operand, signed Q4.28 |
| out_valid | output | 1 | Result present on the outputs this cycle |
| out_tag | output | 4 | Tag of the result |
| out_x | output | 32 | Final X, signed Q4.28 |
| out_y | output | 32 | Final Y, signed Q4.28 |
| out_z | output | 32 | Final Z, signed Q4.28 |

## Verification
Two samples of different geometries and modes can occupy neighbouring stages in the same cycle. In that case one stage applies a hyperbolic repeated shift while the next applies a circular or linear angle. The bench provokes this with a long stream of back-to-back samples whose selector, mode and operands vary on every clock, with occasional gaps. Every result is judged against a behavioural 23-step integer iteration computed from its own operands. Its arrival cycle and tag are judged as well. A reset is also applied while the pipe is full. The bench confirms that nothing valid emerges afterwards until fresh samples have traversed all stages.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DW     = 32;
    localparam int FRAC   = 28;
    localparam int TAGW   = 4;
    localparam int NSTAGE = 23;
    localparam int SHW    = $clog2(NSTAGE + 1);
    localparam int NTERMS = 40;

    typedef enum logic [1:0] {
        CS_LIN  = 2'b00,
        CS_CIRC = 2'b01,
        CS_RSV  = 2'b10,
        CS_HYP  = 2'b11
    } coord_e;

    typedef struct packed {
        logic                   valid;
        coord_e                 coord;
        logic                   vect;
        logic [TAGW-1:0]        tag;
        logic signed [DW-1:0]   x;
        logic signed [DW-1:0]   y;
        logic signed [DW-1:0]   z;
    } lane_t;

    // Shift used by stage idx in the hyperbolic system: repeats at 4 and 13
    function automatic int hyp_shift(input int idx);
        if (idx < 4)       return idx + 1;
        else if (idx < 14) return idx;
        else               return idx - 1;
    endfunction

    // Power series for atan (sgn=-1) or atanh (sgn=+1), valid for t <= 0.5
    function automatic real arc_series(input real t, input real sgn);
        real acc;
        real pw;
        real coef;
        acc  = 0.0;
        pw   = t;
        coef = 1.0;
        for (int k = 0; k < NTERMS; k++) begin
            acc  = acc + coef * pw / real'(2 * k + 1);
            pw   = pw * t * t;
            coef = coef * sgn;
        end
        return acc;
    endfunction

    function automatic real circ_angle(input int s);
        if (s == 0) return 0.7853981633974483;
        return arc_series(1.0 / (2.0 ** s), -1.0);
    endfunction

    function automatic real hyp_angle(input int s);
        return arc_series(1.0 / (2.0 ** s), 1.0);
    endfunction

    function automatic logic signed [DW-1:0] to_fix(input real v);
        longint r;
        r = longint'($rtoi(v * (2.0 ** FRAC) + 0.5));
        return r[DW-1:0];
    endfunction

endpackage

// File: rtl/cordic_const_sel.sv
module cordic_const_sel
    import cordic_pkg::*;
#(
    parameter int IDX = 0
) (
    input  coord_e                  coord,
    output logic [SHW-1:0]          shift,
    output logic signed [DW-1:0]    alpha
);

    localparam int                   SH_LIN  = IDX;
    localparam int                   SH_HYP  = hyp_shift(IDX);
    localparam logic signed [DW-1:0] A_LIN   = to_fix(1.0 / (2.0 ** IDX));
    localparam logic signed [DW-1:0] A_CIRC  = to_fix(circ_angle(IDX));
    localparam logic signed [DW-1:0] A_HYP   = to_fix(hyp_angle(SH_HYP));

    always_comb begin
        case (coord)
            CS_CIRC: begin
                shift = SHW'(SH_LIN);
                alpha = A_CIRC;
            end
            CS_HYP: begin
                shift = SHW'(SH_HYP);
                alpha = A_HYP;
            end
            default: begin
                shift = SHW'(SH_LIN);
                alpha = A_LIN;
            end
        endcase
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  lane_t   in_l,
    output lane_t   out_l
);

    logic [SHW-1:0]         sh;
    logic signed [DW-1:0]   alpha;

    cordic_const_sel #(.IDX(IDX)) u_sel (
        .coord (in_l.coord),
        .shift (sh),
        .alpha (alpha)
    );

    lane_t                  lane_d;
    lane_t                  lane_q;
    logic signed [DW-1:0]   x_in;
    logic signed [DW-1:0]   y_in;
    logic signed [DW-1:0]   z_in;
    logic signed [DW-1:0]   x_sh;
    logic signed [DW-1:0]   y_sh;
    logic                   d_pos;

    always_comb begin
        lane_d = in_l;
        x_in   = in_l.x;
        y_in   = in_l.y;
        z_in   = in_l.z;
        x_sh   = x_in >>> sh;
        y_sh   = y_in >>> sh;
        // d = +1: rotation on Z >= 0, vectoring on Y < 0
        d_pos  = in_l.vect ? y_in[DW-1] : ~z_in[DW-1];

        if (d_pos) begin
            lane_d.y = y_in + x_sh;
            lane_d.z = z_in - alpha;
        end else begin
            lane_d.y = y_in - x_sh;
            lane_d.z = z_in + alpha;
        end

        case (in_l.coord)
            CS_CIRC: lane_d.x = d_pos ? (x_in - y_sh) : (x_in + y_sh);
            CS_HYP:  lane_d.x = d_pos ? (x_in + y_sh) : (x_in - y_sh);
            default: lane_d.x = x_in;
        endcase
    end

    always_ff @(posedge clk) begin
        lane_q <= lane_d;
        if (rst) begin
            lane_q.valid <= 1'b0;
        end
    end

    assign out_l = lane_q;

    p_valid_fwd_r9: assert property (@(posedge clk) disable iff (rst)
        in_l.valid |=> out_l.valid);

    p_bubble_fwd_r10: assert property (@(posedge clk) disable iff (rst)
        !in_l.valid |=> !out_l.valid);

    p_tag_carry_r1: assert property (@(posedge clk) disable iff (rst)
        in_l.valid |=> (out_l.tag == $past(in_l.tag)) && (out_l.coord == $past(in_l.coord))
                       && (out_l.vect == $past(in_l.vect)));

    p_lin_x_hold_r2: assert property (@(posedge clk) disable iff (rst)
        in_l.valid && (in_l.coord == CS_LIN || in_l.coord == CS_RSV) |=> out_l.x == $past(in_l.x));

    p_rot_z_down_r8: assert property (@(posedge clk) disable iff (rst)
        in_l.valid && !in_l.vect && !in_l.z[DW-1] |=> $signed(out_l.z) <= $signed($past(in_l.z)));

    p_vec_y_up_r8: assert property (@(posedge clk) disable iff (rst)
        in_l.valid && in_l.vect && in_l.y[DW-1] && !in_l.x[DW-1]
        |=> $signed(out_l.y) >= $signed($past(in_l.y)));

endmodule

// File: rtl/cordic_core.sv
module cordic_core
    import cordic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_coord,
    input  logic                in_vect,
    input  logic [TAGW-1:0]     in_tag,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [DW-1:0] in_z,
    output logic                out_valid,
    output logic [TAGW-1:0]     out_tag,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y,
    output logic signed [DW-1:0] out_z
);

    lane_t chain [NSTAGE+1];

    always_comb begin
        chain[0].valid = in_valid;
        chain[0].coord = coord_e'(in_coord);
        chain[0].vect  = in_vect;
        chain[0].tag   = in_tag;
        chain[0].x     = in_x;
        chain[0].y     = in_y;
        chain[0].z     = in_z;
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        cordic_stage #(.IDX(g)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .in_l  (chain[g]),
            .out_l (chain[g+1])
        );
    end

    assign out_valid = chain[NSTAGE].valid;
    assign out_tag   = chain[NSTAGE].tag;
    assign out_x     = chain[NSTAGE].x;
    assign out_y     = chain[NSTAGE].y;
    assign out_z     = chain[NSTAGE].z;

endmodule

// File: tb/test_cordic_core.sv
module test_cordic_core;

    localparam int  CLK_PERIOD = 10;
    localparam int  LAT        = 23;
    localparam real SCALE      = 268435456.0;
    localparam real TOL        = 1.0e-5;
    localparam int  WATCHDOG   = 100000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [1:0]         in_coord = 2'b00;
    logic               in_vect = 1'b0;
    logic [3:0]         in_tag = '0;
    logic signed [31:0] in_x = '0;
    logic signed [31:0] in_y = '0;
    logic signed [31:0] in_z = '0;
    logic               out_valid;
    logic [3:0]         out_tag;
    logic signed [31:0] out_x;
    logic signed [31:0] out_y;
    logic signed [31:0] out_z;

    cordic_core i_cordic_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_coord(in_coord), .in_vect(in_vect),
        .in_tag(in_tag), .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
        .out_tag(out_tag), .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        longint x, y, z;
        int     tag;
        longint t;
    } exp_t;
    exp_t q[$];
    int   hsched[$];

    task automatic fail(input string req, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic fail_r(input string req, input string what, input real act, input real exp);
        errors++;
        $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
    endtask

    function automatic longint fx(input real r);
        return longint'($rtoi(r * SCALE + ((r >= 0.0) ? 0.5 : -0.5)));
    endfunction

    function automatic longint wrap32(input longint v);
        int t;
        t = int'(v);
        return longint'(t);
    endfunction

    // Behavioural iteration of the equations, one micro-rotation per step
    function automatic void model(input logic [1:0] c, input logic v,
                                  input longint x0, input longint y0, input longint z0,
                                  output longint xo, output longint yo, output longint zo);
        longint x, y, z, xn, a;
        int     s, m, d;
        x = x0; y = y0; z = z0;
        m = (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
        for (int i = 0; i < LAT; i++) begin
            if (c == 2'b11) begin
                s = hsched[i];
                a = fx($atanh(1.0 / (2.0 ** s)));
            end else if (c == 2'b01) begin
                s = i;
                a = fx($atan(1.0 / (2.0 ** s)));
            end else begin
                s = i;
                a = fx(1.0 / (2.0 ** s));
            end
            if (v) d = (y < 0) ? 1 : -1;
            else   d = (z >= 0) ? 1 : -1;
            xn = x - m * d * (y >>> s);
            y  = wrap32(y + d * (x >>> s));
            x  = wrap32(xn);
            z  = wrap32(z - d * a);
        end
        xo = x; yo = y; zo = z;
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Present one sample at the current negedge and record the expectation
    task automatic issue(input logic [1:0] c, input logic v, input longint x, input longint y,
                         input longint z, input int tag);
        exp_t e;
        in_valid = 1'b1; in_coord = c; in_vect = v; in_tag = tag[3:0];
        in_x = x[31:0]; in_y = y[31:0]; in_z = z[31:0];
        model(c, v, x, y, z, e.x, e.y, e.z);
        e.tag = tag; e.t = cyc;
        q.push_back(e);
    endtask

    // Pipeline monitor: latency, tag and value against the model (R1, R10, R9)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            if (q.size() == 0) begin
                checks++;
                fail("R9", "valid with nothing in flight", 1, 0);
            end else begin
                e = q.pop_front();
                checks++;
                if (cyc - e.t != LAT) fail("R1", "latency", cyc - e.t, LAT);
                checks++;
                if (int'(out_tag) != e.tag) fail("R1", "tag", out_tag, e.tag);
                checks++;
                if (absl(longint'(out_x) - e.x) > 8) fail("R10", "x", out_x, e.x);
                else if (absl(longint'(out_y) - e.y) > 8) fail("R10", "y", out_y, e.y);
                else if (absl(longint'(out_z) - e.z) > 8) fail("R10", "z", out_z, e.z);
            end
        end
    end

    task automatic cmp_real(input string req, input string what, input logic signed [31:0] act,
                            input real exp);
        real a;
        a = $itor(act) / SCALE;
        checks++;
        if ((a - exp > TOL) || (exp - a > TOL)) fail_r(req, what, a, exp);
    endtask

    // Single isolated operation; outputs read when its result is due
    task automatic run_one(input string req, input logic [1:0] c, input logic v,
                           input real x, input real y, input real z,
                           input real ex, input real ey, input real ez,
                           input bit chx, input bit chy, input bit chz, input int tag);
        issue(c, v, fx(x), fx(y), fx(z), tag);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) fail(req, "valid at due cycle", out_valid, 1);
        if (chx) cmp_real(req, "x", out_x, ex);
        if (chy) cmp_real(req, "y", out_y, ey);
        if (chz) cmp_real(req, "z", out_z, ez);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    real kc, kh;

    initial begin
        for (int s = 1; hsched.size() < LAT; s++) begin
            hsched.push_back(s);
            if ((s == 4 || s == 13) && hsched.size() < LAT) hsched.push_back(s);
        end
        kc = 1.0;
        for (int s = 0; s < LAT; s++) kc = kc * $sqrt(1.0 + 1.0 / (4.0 ** s));
        kh = 1.0;
        for (int i = 0; i < LAT; i++) kh = kh * $sqrt(1.0 - 1.0 / (4.0 ** hsched[i]));

        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) fail("R9", "valid during reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) fail("R9", "valid after reset", out_valid, 0);

        // R2: linear rotation, y + x*z, x unchanged
        run_one("R2", 2'b00, 1'b0, 1.5, 0.5, -1.75, 1.5, -2.125, 0.0, 1, 1, 1, 1);
        // R3: linear vectoring, z + y/x
        run_one("R3", 2'b00, 1'b1, 2.0, 3.0, 0.0, 2.0, 0.0, 1.5, 1, 1, 1, 2);
        // R4: circular rotation with pre-divided gain
        run_one("R4", 2'b01, 1'b0, 1.0 / kc, 0.0, 0.5, 0.8775825618903728, 0.479425538604203, 0.0,
                1, 1, 1, 3);
        // R5: circular vectoring, atan and magnitude
        run_one("R5", 2'b01, 1'b1, 1.0, 1.0, 0.0, kc * $sqrt(2.0), 0.0, 0.7853981633974483,
                1, 1, 1, 4);
        // R6: hyperbolic rotation with repeated shifts
        run_one("R6", 2'b11, 1'b0, 1.0 / kh, 0.0, 0.5, 1.1276259652063807, 0.5210953054937474, 0.0,
                1, 1, 1, 5);
        // R7: hyperbolic vectoring, atanh and hyperbolic magnitude
        run_one("R7", 2'b11, 1'b1, 2.0, 1.0, 0.0, kh * $sqrt(3.0), 0.0, 0.5493061443340549,
                1, 1, 1, 6);
        // R8: negative angle gives mirrored circular result
        run_one("R8", 2'b01, 1'b0, 1.0 / kc, 0.0, -0.5, 0.8775825618903728, -0.479425538604203, 0.0,
                1, 1, 1, 7);
        // R8: vectoring from below the axis gives negative angle
        run_one("R8", 2'b01, 1'b1, 1.0, -1.0, 0.0, kc * $sqrt(2.0), 0.0, -0.7853981633974483,
                1, 1, 1, 8);
        // R11: reserved selector acts as linear
        run_one("R11", 2'b10, 1'b0, 1.5, 0.5, 1.25, 1.5, 2.375, 0.0, 1, 1, 1, 9);

        // R10: back-to-back mixed stream, then a stream with gaps
        for (int n = 0; n < 400; n++) begin
            logic [1:0] c;
            logic       v;
            longint     x, y, z;
            c = 2'($urandom_range(0, 3));
            v = 1'($urandom_range(0, 1));
            x = fx(0.5) + longint'($urandom_range(0, 32'h0800_0000));
            y = longint'($urandom_range(0, 32'h0A00_0000)) - longint'(32'h0500_0000);
            z = longint'($urandom_range(0, 32'h1000_0000)) - longint'(32'h0800_0000);
            if (n >= 250 && $urandom_range(0, 3) == 0) in_valid = 1'b0;
            else issue(c, v, x, y, z, n % 16);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        checks++;
        if (q.size() != 0) fail("R10", "results missing", q.size(), 0);

        // R9: reset with the pipe full drops everything in flight
        for (int n = 0; n < 30; n++) begin
            issue(2'b01, 1'b0, fx(0.6), fx(0.1), fx(0.3), n % 16);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < LAT + 3; n++) begin
            checks++;
            if (out_valid !== 1'b0) fail("R9", "valid after mid-stream reset", out_valid, 0);
            @(negedge clk);
        end

        // R1: fresh sample after reset still arrives on time
        run_one("R1", 2'b00, 1'b0, 1.0, 0.0, 0.75, 1.0, 0.75, 0.0, 1, 1, 1, 15);

        finish_run();
    end

endmodule